// File: doc/BRIEF.md
# Indexed Effective-Address Extension Decoder

This block forms a 32-bit effective address for the indexed addressing modes of a processor front end. It takes 16-bit extension words, one per cycle, over a valid/ready handshake. The first word is decoded in one of two layouts. The short layout carries a signed 8-bit displacement. The long layout lets the base, the index and the displacement each be dropped on its own, and it can be followed by zero, one or two displacement words. The base is either an address register value or the program-counter value, chosen by a select input.

The block does not read a register file. Once the last extension word has been taken, it raises `idx_fetch` for one cycle and presents the index register kind and number. An external file returns the register value on `idx_value` in that same cycle. The base inputs are sampled in that cycle too. One cycle later the block pulses `ea_valid` and holds the address, the count of extension words consumed and an illegal-encoding flag until the next result.

Top module: `idx_ea_decoder`

## Requirements
- R1: In the first extension word, bit 15 gives the index register kind (0 data, 1 address) and bits 14..12 give its number. Both appear on `idx_is_addr` and `idx_num` while `idx_fetch` is high.
- R2: Bit 11 set uses the index value as a full 32-bit value. Bit 11 clear sign-extends the low 16 bits of the index value. Bits 10..9 scale the index by 1, 2, 4 or 8 for codes 0 to 3.
- R3: Bit 8 clear selects the short layout: address = base + scaled index + sign-extended bits 7..0. Neither base nor index can be dropped in this layout.
- R4: Bit 8 set selects the long layout. There, bit 7 set drops the base and bit 6 set drops the index, and a dropped term adds zero. When the base is dropped, the program-counter base is ignored exactly like the address-register base.
- R5: In the long layout, bits 5..4 give the displacement size. Code 1 means no displacement. Code 2 means one word, sign-extended. Code 3 means two words, upper half first.
- R6: `ext_words` reports the extension words consumed: 1 for the short layout, and 1, 2 or 3 for long-layout size codes 1, 2 and 3. An illegal long-layout word reports 1 and takes no displacement words.
- R7: `ea_illegal` is set for a long-layout word in any of these cases: size code 0, bit 3 set, bits 2..0 nonzero (with or without the index dropped), or base and index dropped with size code 1. When it is set, `ea_addr` is zero.
- R8: `word_ready` is high in every state except the index-fetch cycle. A word counts only on a clock edge where both `word_valid` and `word_ready` are high, so idle gaps between words are allowed. A word offered while `word_ready` is low has no effect.
- R9: `idx_fetch` is high for exactly the one cycle after the edge that accepts the final word. `idx_value`, `an_base`, `pc_base` and `base_is_pc` are sampled then. `ea_valid` is high for exactly the following cycle.
- R10: After reset, `word_ready` is 1 and `ea_valid` and `idx_fetch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Extension word offered |
| word_data | input | 16 | Extension word |
| word_ready | output | 1 | Block can take a word |
| an_base | input | 32 | Address-register base value |
| pc_base | input | 32 | Program-counter base value |
| base_is_pc | input | 1 | Use `pc_base` as the base |
| idx_fetch | output | 1 | Index value wanted this cycle |
| idx_is_addr | output | 1 | Index register kind, 1 = address |
| idx_num | output | 3 | Index register number |
| idx_value | input | 32 | Index register contents |
| ea_valid | output | 1 | Result pulse |
| ea_addr | output | 32 | Effective address |
| ext_words | output | 2 | Extension words consumed |
| ea_illegal | output | 1 | Illegal extension encoding |

## Verification
The bench uses an index register file in which each register number gives a distinct value, with the upper half differing from the lower half. A design that swaps register kind or number, or gets the word/long choice wrong, therefore produces a visibly wrong address. A wrong scale also shows up, since scale codes 1 to 8 are all exercised. The vectors cover a negative short displacement, a negative one-word displacement and a two-word displacement. A design that fails to sign-extend, or that joins the halves in the wrong order, lands at the wrong address. Every illegal case is applied on its own, including the all-dropped case and nonzero low bits with the index kept. So is a program-counter base that must be ignored when dropped, which would leak into the address if mishandled. Directed tests insert idle gaps between words and offer a word during the fetch cycle. A design that miscounts the handshake would either mis-assemble the displacement or emit a spurious result.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    localparam int EA_W  = 32;
    localparam int EXT_W = 16;
    localparam int BRIEF_DISP_W = 8;
    localparam int REG_NUM_W = 3;
    localparam int SCALE_W = 2;
    localparam int WCNT_W = 2;

    // displacement size codes of the long layout
    localparam logic [1:0] DSZ_RSVD = 2'b00;
    localparam logic [1:0] DSZ_NONE = 2'b01;
    localparam logic [1:0] DSZ_WORD = 2'b10;
    localparam logic [1:0] DSZ_LONG = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DHI   = 2'd1,
        ST_DLO   = 2'd2,
        ST_FETCH = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic                    idx_is_addr;
        logic [REG_NUM_W-1:0]    idx_num;
        logic                    idx_long;
        logic [SCALE_W-1:0]      scale;
        logic                    full;
        logic                    base_sup;
        logic                    idx_sup;
        logic [1:0]              dsz;
        logic [BRIEF_DISP_W-1:0] brief_disp;
        logic                    illegal;
        logic [WCNT_W-1:0]       words;
    } ext_fields_t;

endpackage

// File: rtl/idx_ext_fields.sv
module idx_ext_fields
    import idx_ea_pkg::*;
(
    input  logic [EXT_W-1:0] word,
    output ext_fields_t      fld
);
    logic is_full;
    logic bad_dsz;
    logic bad_bit3;
    logic bad_low;
    logic all_sup;

    assign is_full  = word[8];
    assign bad_dsz  = (word[5:4] == DSZ_RSVD);
    assign bad_bit3 = word[3];
    assign bad_low  = (word[2:0] != 3'b000);
    assign all_sup  = word[7] && word[6] && (word[5:4] == DSZ_NONE);

    always_comb begin
        fld             = '0;
        fld.idx_is_addr = word[15];
        fld.idx_num     = word[14:12];
        fld.idx_long    = word[11];
        fld.scale       = word[10:9];
        fld.full        = is_full;
        if (is_full) begin
            fld.base_sup = word[7];
            fld.idx_sup  = word[6];
            fld.dsz      = word[5:4];
            fld.illegal  = bad_dsz || bad_bit3 || bad_low || all_sup;
            if (fld.illegal) begin
                fld.words = 2'd1;
            end else begin
                unique case (word[5:4])
                    DSZ_WORD: fld.words = 2'd2;
                    DSZ_LONG: fld.words = 2'd3;
                    default:  fld.words = 2'd1;
                endcase
            end
        end else begin
            fld.brief_disp = word[7:0];
            fld.words      = 2'd1;
        end
    end

endmodule

// File: rtl/idx_index_scale.sv
module idx_index_scale
    import idx_ea_pkg::*;
#(
    parameter int W = EA_W
) (
    input  logic [W-1:0]       raw,
    input  logic               use_long,
    input  logic [SCALE_W-1:0] scale,
    output logic [W-1:0]       scaled
);
    localparam int NSCALE = 1 << SCALE_W;

    logic [W-1:0] sized;
    logic [W-1:0] cand [NSCALE];

    assign sized = use_long ? raw : {{(W-EXT_W){raw[EXT_W-1]}}, raw[EXT_W-1:0]};

    for (genvar s = 0; s < NSCALE; s++) begin : g_scale
        if (s == 0) begin : g_unit
            assign cand[s] = sized;
        end else begin : g_shift
            assign cand[s] = {sized[W-1-s:0], {s{1'b0}}};
        end
    end

    assign scaled = cand[scale];

endmodule

// File: rtl/idx_ea_sum.sv
module idx_ea_sum
    import idx_ea_pkg::*;
#(
    parameter int W = EA_W
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] index,
    input  logic [W-1:0] disp,
    input  logic         base_sup,
    input  logic         idx_sup,
    output logic [W-1:0] ea
);
    logic [W-1:0] base_term;
    logic [W-1:0] idx_term;

    assign base_term = base_sup ? '0 : base;
    assign idx_term  = idx_sup  ? '0 : index;
    assign ea        = base_term + idx_term + disp;

endmodule

// File: rtl/idx_ea_decoder.sv
module idx_ea_decoder
    import idx_ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [EXT_W-1:0]     word_data,
    output logic                 word_ready,
    input  logic [EA_W-1:0]      an_base,
    input  logic [EA_W-1:0]      pc_base,
    input  logic                 base_is_pc,
    output logic                 idx_fetch,
    output logic                 idx_is_addr,
    output logic [REG_NUM_W-1:0] idx_num,
    input  logic [EA_W-1:0]      idx_value,
    output logic                 ea_valid,
    output logic [EA_W-1:0]      ea_addr,
    output logic [WCNT_W-1:0]    ext_words,
    output logic                 ea_illegal
);
    typedef struct packed {
        dec_state_e        st;
        ext_fields_t       fld;
        logic [EA_W-1:0]   disp;
        logic [EA_W-1:0]   ea;
        logic [WCNT_W-1:0] words;
        logic              illegal;
        logic              done;
    } dec_regs_t;

    dec_regs_t r_d, r_q;

    ext_fields_t     new_fld;
    logic [EA_W-1:0] base_sel;
    logic [EA_W-1:0] idx_scaled;
    logic [EA_W-1:0] sum_ea;
    logic            take;

    idx_ext_fields u_fields (
        .word (word_data),
        .fld  (new_fld)
    );

    idx_index_scale #(.W(EA_W)) u_scale (
        .raw      (idx_value),
        .use_long (r_q.fld.idx_long),
        .scale    (r_q.fld.scale),
        .scaled   (idx_scaled)
    );

    assign base_sel = base_is_pc ? pc_base : an_base;

    idx_ea_sum #(.W(EA_W)) u_sum (
        .base     (base_sel),
        .index    (idx_scaled),
        .disp     (r_q.disp),
        .base_sup (r_q.fld.base_sup),
        .idx_sup  (r_q.fld.idx_sup),
        .ea       (sum_ea)
    );

    assign word_ready = (r_q.st != ST_FETCH);
    assign take       = word_valid && word_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (take) begin
                    r_d.fld  = new_fld;
                    r_d.disp = new_fld.full ? '0
                             : {{(EA_W-BRIEF_DISP_W){new_fld.brief_disp[BRIEF_DISP_W-1]}},
                                new_fld.brief_disp};
                    if (new_fld.full && !new_fld.illegal && new_fld.dsz == DSZ_WORD) begin
                        r_d.st = ST_DLO;
                    end else if (new_fld.full && !new_fld.illegal && new_fld.dsz == DSZ_LONG) begin
                        r_d.st = ST_DHI;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end
            end
            ST_DHI: begin
                if (take) begin
                    r_d.disp[EA_W-1 -: EXT_W] = word_data;
                    r_d.st = ST_DLO;
                end
            end
            ST_DLO: begin
                if (take) begin
                    if (r_q.fld.dsz == DSZ_WORD) begin
                        r_d.disp = {{(EA_W-EXT_W){word_data[EXT_W-1]}}, word_data};
                    end else begin
                        r_d.disp[EXT_W-1:0] = word_data;
                    end
                    r_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.ea      = r_q.fld.illegal ? '0 : sum_ea;
                r_d.words   = r_q.fld.words;
                r_d.illegal = r_q.fld.illegal;
                r_d.done    = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idx_fetch   = (r_q.st == ST_FETCH);
    assign idx_is_addr = r_q.fld.idx_is_addr;
    assign idx_num     = r_q.fld.idx_num;
    assign ea_valid    = r_q.done;
    assign ea_addr     = r_q.ea;
    assign ext_words   = r_q.words;
    assign ea_illegal  = r_q.illegal;

    // R8
    ready_fetch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ready && idx_fetch));

    // R9
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fetch |=> !idx_fetch);

    // R9
    fetch_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fetch |=> ea_valid);

    // R9
    valid_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> $past(idx_fetch));

    // R7
    illegal_zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && ea_illegal) |-> (ea_addr == '0));

    // R6
    words_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> (ext_words != 2'd0));

    // R6
    illegal_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && ea_illegal) |-> (ext_words == 2'd1));

endmodule

// File: tb/tb_idx_ea_decoder.sv
module tb_idx_ea_decoder;
    import idx_ea_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_ready;
    logic [31:0] an_base = '0;
    logic [31:0] pc_base = '0;
    logic        base_is_pc = 1'b0;
    logic        idx_fetch;
    logic        idx_is_addr;
    logic [2:0]  idx_num;
    logic [31:0] idx_value;
    logic        ea_valid;
    logic [31:0] ea_addr;
    logic [1:0]  ext_words;
    logic        ea_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    idx_ea_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .an_base(an_base), .pc_base(pc_base), .base_is_pc(base_is_pc),
        .idx_fetch(idx_fetch), .idx_is_addr(idx_is_addr), .idx_num(idx_num),
        .idx_value(idx_value),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .ext_words(ext_words),
        .ea_illegal(ea_illegal)
    );

    // R1: bench register file, every register distinct in both halves
    always_comb begin
        if (idx_is_addr) idx_value = {16'h1234, 16'hFFF0} - {29'd0, idx_num};
        else             idx_value = 32'h0001_0000 + {29'd0, idx_num};
    end

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
        logic [15:0] w2;
        logic [31:0] an;
        logic [31:0] pc;
        logic        sel_pc;
        logic [31:0] ea;
        logic [1:0]  words;
        logic        ill;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        // R1 R2 R3: address index 2, word, x4, disp 0x11
        '{16'hA411, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0000_0FC9, 2'd1, 1'b0},
        // R5: one-word displacement
        '{16'hA520, 16'h1111, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0000_20C9, 2'd2, 1'b0},
        // R5: two-word displacement, upper first
        '{16'hA530, 16'h2222, 16'h1111, 32'h1000, 32'h2_0000, 1'b0, 32'h2222_20C9, 2'd3, 1'b0},
        // R2 R3: data index 3 long x8, pc base, disp -16
        '{16'h3EF0, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b1, 32'h000A_0008, 2'd1, 1'b0},
        // R4 R5: base dropped (pc ignored), D1 word x1, disp 0x8000 sign-extended
        '{16'h11A0, 16'h8000, 16'h0000, 32'h1000, 32'h2_0000, 1'b1, 32'hFFFF_8001, 2'd2, 1'b0},
        // R4: index dropped, long disp
        '{16'h0170, 16'h0001, 16'h0002, 32'h1000, 32'h2_0000, 1'b0, 32'h0001_1002, 2'd3, 1'b0},
        // R2 R5: no displacement, A0 long x2
        '{16'h8B10, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h246A_0FE0, 2'd1, 1'b0},
        // R4: base dropped, D7 word, no disp
        '{16'h7190, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b1, 32'h0000_0007, 2'd1, 1'b0},
        // R4: base and index dropped, word disp only
        '{16'h01E0, 16'h7FFF, 16'h0000, 32'h1000, 32'h2_0000, 1'b1, 32'h0000_7FFF, 2'd2, 1'b0},
        // R7: reserved size code
        '{16'h0100, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1},
        // R7: bit 3 set
        '{16'h0118, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1},
        // R7: low bits nonzero with index dropped
        '{16'h0151, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1},
        // R7: low bits nonzero with index kept
        '{16'h0112, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1},
        // R7: all three dropped
        '{16'h01D0, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1},
        // R6 R7: reserved size with a long size word following is not consumed
        '{16'h0108, 16'h0000, 16'h0000, 32'h1000, 32'h2_0000, 1'b0, 32'h0, 2'd1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        while (!word_ready) @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = 16'hDEAD;
    endtask

    task automatic wait_result(output bit seen);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (ea_valid) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 ready", {31'd0, word_ready}, 32'd1);
        chk("R10 valid", {31'd0, ea_valid}, 32'd0);
        chk("R10 fetch", {31'd0, idx_fetch}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            an_base    = VECS[v].an;
            pc_base    = VECS[v].pc;
            base_is_pc = VECS[v].sel_pc;
            send_word(VECS[v].w0);
            if (VECS[v].words > 2'd1) send_word(VECS[v].w1);
            if (VECS[v].words > 2'd2) send_word(VECS[v].w2);
            wait_result(seen);
            chk("R9 result seen", {31'd0, seen}, 32'd1);
            chk("R2 R3 R4 R5 ea", ea_addr, VECS[v].ea);
            chk("R6 words", {30'd0, ext_words}, {30'd0, VECS[v].words});
            chk("R7 illegal", {31'd0, ea_illegal}, {31'd0, VECS[v].ill});
            @(negedge clk);
        end

        // R9 R1: cycle timing of fetch and result for a short-layout word
        an_base = 32'h1000; base_is_pc = 1'b0;
        send_word(16'hA411);
        chk("R9 fetch cycle", {31'd0, idx_fetch}, 32'd1);
        chk("R8 ready low in fetch", {31'd0, word_ready}, 32'd0);
        chk("R1 idx kind", {31'd0, idx_is_addr}, 32'd1);
        chk("R1 idx num", {29'd0, idx_num}, 32'd2);
        // R8: word offered while not ready is ignored
        word_valid = 1'b1; word_data = 16'h0100;
        @(negedge clk);
        word_valid = 1'b0;
        chk("R9 valid next cycle", {31'd0, ea_valid}, 32'd1);
        chk("R9 ea", ea_addr, 32'h0000_0FC9);
        chk("R8 ready again", {31'd0, word_ready}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 no spurious result", {31'd0, ea_valid}, 32'd0);
            chk("R9 no spurious fetch", {31'd0, idx_fetch}, 32'd0);
        end

        // R8: idle gaps between words of a two-word displacement
        send_word(16'hA530);
        repeat (3) @(negedge clk);
        send_word(16'h2222);
        repeat (2) @(negedge clk);
        chk("R8 gap no result", {31'd0, ea_valid}, 32'd0);
        send_word(16'h1111);
        wait_result(seen);
        chk("R8 gap result", {31'd0, seen}, 32'd1);
        chk("R8 R5 gap ea", ea_addr, 32'h2222_20C9);
        chk("R6 gap words", {30'd0, ext_words}, 32'd3);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule